// File: doc/BRIEF.md
# Packed Decimal Sequential Adder

This block adds two unsigned decimal numbers kept in byte-wide memories, one byte per cycle. Every byte carries two decimal digits, and byte index 0 is the least significant. After a start request the block walks the byte index upward. In each step it reads one byte of each operand, forms the binary sum with the incoming decimal carry, and corrects each digit back into the range 0 to 9. It then writes the corrected byte to a result memory at the same index.

The two operands may differ in length. Past the end of the shorter one, the block treats its bytes as zero. Because the numbers are stored low byte first, a carry out of the top byte needs no shifting: the block writes one extra byte holding 0x01 just above the last one. It then reports the number of bytes written and pulses done. The memories are external. The block drives the read addresses and samples the read data in the same cycle. The result port is a plain write strobe with address and data.

Top module: `bcd_seq_adder`

## Requirements
- R1: After reset, done and resWe are low and resLen reads 0.
- R2: Each byte holds two decimal digits, the lower digit in bits 3:0 and the upper digit in bits 7:4. For valid decimal inputs, every written byte holds two valid digits, and the result memory holds the decimal sum of the two operands.
- R3: A decimal carry out of one byte is added into the next byte, including when the carry ripples across several bytes of 0x99.
- R4: When a carry remains after the last operand byte, exactly one extra byte of value 0x01 is written at index max(lenA, lenB). Lower bytes are left as already written.
- R5: For an operand whose length is below the current index, the read data is ignored and taken as 0x00, whatever the memory returns.
- R6: resLen equals max(lenA, lenB), plus one when a final carry occurred. It is valid while done is high and stays held until the next accepted start.
- R7: done is high for exactly one cycle, in the cycle after the last result write. Result writes go to consecutive addresses starting at 0.
- R8: A start that arrives while an addition is in progress is ignored, together with the lengths presented with it.
- R9: When both lengths are zero, the block writes nothing, reports resLen 0 and still pulses done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an addition (accepted only when idle) |
| lenA | input | LEN_W | Byte count of operand A |
| lenB | input | LEN_W | Byte count of operand B |
| aAddr | output | ADDR_W | Read address into operand A memory |
| aData | input | 8 | Byte read from operand A memory |
| bAddr | output | ADDR_W | Read address into operand B memory |
| bData | input | 8 | Byte read from operand B memory |
| resWe | output | 1 | Result write strobe |
| resAddr | output | LEN_W | Result write address |
| resData | output | 8 | Result write byte |
| done | output | 1 | One-cycle completion pulse |
| resLen | output | LEN_W | Number of result bytes written |

## Verification
The hardest state to reach is a carry that rises in the low bytes and ripples through a long run of 0x99 into the appended byte. This is especially so when the run extends past the end of the shorter operand, where the masked zero bytes must still pass it along. Uniform random digits almost never produce such a chain. The stimulus therefore mixes random operands of one to eight bytes with directed cases: a full-length operand of all nines plus a one-byte one, equal-length nines, and unequal lengths with garbage in the unused memory. A stray start with different lengths is also injected in the middle of a run.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_CARRY = 2'd2,
    ST_FIN   = 2'd3
  } addState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture lengths, clear index and carry
    logic writeSum;    // write corrected byte, advance index
    logic writeCarry;  // write the appended 0x01 byte
  } addStrobe_t;

endpackage

// File: rtl/bcd_byte_add.sv
module bcd_byte_add #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  logic                carryIn,
  output logic [4*DIGITS-1:0] sum,
  output logic                carryOut
);

  logic [DIGITS:0] chain;
  assign chain[0] = carryIn;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic       fix;
    assign raw = {1'b0, opA[4*g +: 4]} + {1'b0, opB[4*g +: 4]} + {4'd0, chain[g]};
    assign fix = (raw > 5'd9);
    assign sum[4*g +: 4] = fix ? (raw[3:0] + 4'd6) : raw[3:0];
    assign chain[g+1] = fix;
  end

  assign carryOut = chain[DIGITS];

endmodule

// File: rtl/bcd_add_dp.sv
module bcd_add_dp
  import bcd_add_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  addStrobe_t       stb,
  input  logic [LEN_W-1:0] lenAIn,
  input  logic [LEN_W-1:0] lenBIn,
  input  logic [7:0]       aData,
  input  logic [7:0]       bData,
  output logic [ADDR_W-1:0] aAddr,
  output logic [ADDR_W-1:0] bAddr,
  output logic             resWe,
  output logic [LEN_W-1:0] resAddr,
  output logic [7:0]       resData,
  output logic [LEN_W-1:0] resLen,
  output logic [LEN_W-1:0] maxLen,
  output logic             zeroLen,
  output logic             isLast,
  output logic             carryNext
);

  logic [LEN_W-1:0] lenAQ, lenBQ, maxLenQ, idxQ;
  logic             carryQ;
  logic [7:0]       opA, opB, sumByte;
  logic             sumCarry;

  // operands past their own length read as zero
  assign opA = (idxQ < lenAQ) ? aData : 8'h00;
  assign opB = (idxQ < lenBQ) ? bData : 8'h00;

  bcd_byte_add #(.DIGITS(2)) u_add (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryQ),
    .sum      (sumByte),
    .carryOut (sumCarry)
  );

  assign aAddr     = idxQ[ADDR_W-1:0];
  assign bAddr     = idxQ[ADDR_W-1:0];
  assign resWe     = stb.writeSum | stb.writeCarry;
  assign resAddr   = idxQ;
  assign resData   = stb.writeCarry ? 8'h01 : sumByte;
  assign resLen    = idxQ;
  assign maxLen    = maxLenQ;
  assign zeroLen   = (lenAIn == '0) && (lenBIn == '0);
  assign isLast    = (idxQ + 1'b1 == maxLenQ);
  assign carryNext = sumCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenAQ   <= '0;
      lenBQ   <= '0;
      maxLenQ <= '0;
      idxQ    <= '0;
      carryQ  <= 1'b0;
    end else if (stb.load) begin
      lenAQ   <= lenAIn;
      lenBQ   <= lenBIn;
      maxLenQ <= (lenAIn > lenBIn) ? lenAIn : lenBIn;
      idxQ    <= '0;
      carryQ  <= 1'b0;
    end else if (stb.writeSum) begin
      idxQ    <= idxQ + 1'b1;
      carryQ  <= sumCarry;
    end else if (stb.writeCarry) begin
      idxQ    <= idxQ + 1'b1;
      carryQ  <= 1'b0;
    end
  end

  // R7: result addresses climb by one between back-to-back writes
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && $past(resWe)) |-> (resAddr == $past(resAddr) + 1'b1));

  // R2: valid decimal inputs give a valid decimal result byte
  a_r2_digits_valid: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && opA[3:0] <= 4'd9 && opA[7:4] <= 4'd9 &&
     opB[3:0] <= 4'd9 && opB[7:4] <= 4'd9)
    |-> (resData[3:0] <= 4'd9 && resData[7:4] <= 4'd9));

endmodule

// File: rtl/bcd_add_ctrl.sv
module bcd_add_ctrl
  import bcd_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       zeroLen,
  input  logic       isLast,
  input  logic       carryNext,
  output addStrobe_t stb,
  output logic       done,
  output logic       busy
);

  addState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    done   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateD   = zeroLen ? ST_FIN : ST_ADD;
        end
      end
      ST_ADD: begin
        stb.writeSum = 1'b1;
        if (isLast) stateD = carryNext ? ST_CARRY : ST_FIN;
      end
      ST_CARRY: begin
        stb.writeCarry = 1'b1;
        stateD         = ST_FIN;
      end
      ST_FIN: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R7: done never lasts two cycles
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: the extra byte only follows a last byte that carried out
  a_r4_carry_after_cout: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CARRY) |-> $past(stateQ == ST_ADD && isLast && carryNext));

endmodule

// File: rtl/bcd_seq_adder.sv
module bcd_seq_adder
  import bcd_add_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenB,
  output logic [ADDR_W-1:0] aAddr,
  input  logic [7:0]        aData,
  output logic [ADDR_W-1:0] bAddr,
  input  logic [7:0]        bData,
  output logic              resWe,
  output logic [LEN_W-1:0]  resAddr,
  output logic [7:0]        resData,
  output logic              done,
  output logic [LEN_W-1:0]  resLen
);

  addStrobe_t       stb;
  logic             zeroLen, isLast, carryNext, busy;
  logic [LEN_W-1:0] maxLen;

  bcd_add_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .zeroLen   (zeroLen),
    .isLast    (isLast),
    .carryNext (carryNext),
    .stb       (stb),
    .done      (done),
    .busy      (busy)
  );

  bcd_add_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .lenAIn    (lenA),
    .lenBIn    (lenB),
    .aData     (aData),
    .bData     (bData),
    .aAddr     (aAddr),
    .bAddr     (bAddr),
    .resWe     (resWe),
    .resAddr   (resAddr),
    .resData   (resData),
    .resLen    (resLen),
    .maxLen    (maxLen),
    .zeroLen   (zeroLen),
    .isLast    (isLast),
    .carryNext (carryNext)
  );

  // R8: captured length stays put for the whole run
  a_r8_len_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(maxLen));

  // R6: reported length is the longer operand, plus at most one
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (resLen == maxLen || resLen == maxLen + 1'b1));

endmodule

// File: tb/tb_bcd_seq_adder.sv
module tb_bcd_seq_adder;

  localparam int ADDR_W = 4;
  localparam int LEN_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  lenA = '0, lenB = '0;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic [7:0]        aData, bData;
  logic              resWe;
  logic [LEN_W-1:0]  resAddr;
  logic [7:0]        resData;
  logic              done;
  logic [LEN_W-1:0]  resLen;

  logic [7:0] memA [DEPTH];
  logic [7:0] memB [DEPTH];
  logic [7:0] memR [2*DEPTH];
  logic [7:0] expR [2*DEPTH];
  int         expLen;
  int         writeCnt;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  assign aData = memA[aAddr];
  assign bData = memB[bAddr];

  always @(posedge clk) if (resWe) begin
    memR[resAddr] <= resData;
    writeCnt      <= writeCnt + 1;
  end

  bcd_seq_adder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .lenA(lenA), .lenB(lenB),
    .aAddr(aAddr), .aData(aData), .bAddr(bAddr), .bData(bData),
    .resWe(resWe), .resAddr(resAddr), .resData(resData),
    .done(done), .resLen(resLen));

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] randBcd();
    return {4'($urandom_range(9)), 4'($urandom_range(9))};
  endfunction

  // decimal value of the first n bytes of a memory
  function automatic longint unsigned toInt(input logic [7:0] m [DEPTH], input int n);
    longint unsigned v = 0;
    for (int i = n - 1; i >= 0; i--) v = v * 100 + m[i][7:4] * 10 + m[i][3:0];
    return v;
  endfunction

  // expected result for operands up to 8 bytes
  task automatic buildExpect(input int la, input int lb);
    longint unsigned s = toInt(memA, la) + toInt(memB, lb);
    int mx = (la > lb) ? la : lb;
    for (int i = 0; i < 2*DEPTH; i++) expR[i] = 8'hEE;
    for (int i = 0; i < mx; i++) begin
      expR[i] = {4'((s / 10) % 10), 4'(s % 10)};
      s = s / 100;
    end
    expLen = mx;
    if (s != 0) begin
      expR[mx] = 8'h01;
      expLen   = mx + 1;
    end
  endtask

  // run one addition; stray = inject a start mid-run (R8)
  task automatic runAdd(input int la, input int lb, input bit stray, input string tag);
    int cyc = 0;
    int bad = 0;
    for (int i = 0; i < 2*DEPTH; i++) memR[i] = 8'hEE;
    writeCnt = 0;
    @(negedge clk);
    lenA = LEN_W'(la); lenB = LEN_W'(lb); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lenA = LEN_W'(DEPTH); lenB = LEN_W'(1);
    if (stray) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    // R7: done appears only after all writes, in the following cycle
    check(done && writeCnt == expLen, {tag, " R7 done after writes"}, writeCnt, expLen);
    check(resLen == LEN_W'(expLen), {tag, " R6 resLen"}, resLen, expLen);
    for (int i = 0; i < 2*DEPTH; i++)
      if (memR[i] !== expR[i]) begin
        if (bad == 0) check(1'b0, {tag, " R2 result byte"}, memR[i], expR[i]);
        bad++;
      end
    if (bad == 0) check(1'b1, {tag, " R2 result"}, 0, 0);
    @(negedge clk);
    check(!done, {tag, " R7 single-cycle done"}, done, 0);
    check(resLen == LEN_W'(expLen), {tag, " R6 resLen held"}, resLen, expLen);
  endtask

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < DEPTH; i++) begin memA[i] = 8'h00; memB[i] = 8'h00; end
    for (int i = 0; i < 2*DEPTH; i++) memR[i] = 8'hEE;
    writeCnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !resWe && resLen == '0, "R1 reset outputs", {done, resWe, resLen}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 carry ripple across 0x99 bytes: 0x999999 + 0x01
    memA[0] = 8'h99; memA[1] = 8'h99; memA[2] = 8'h99; memA[3] = 8'h12;
    memB[0] = 8'h01;
    for (int i = 1; i < DEPTH; i++) memB[i] = 8'h77; // R5 garbage beyond lenB
    buildExpect(4, 1);
    runAdd(4, 1, 1'b0, "R3 ripple R5 masked");

    // R4 appended carry byte, equal lengths
    for (int i = 0; i < DEPTH; i++) begin memA[i] = 8'h99; memB[i] = 8'h99; end
    buildExpect(3, 3);
    runAdd(3, 3, 1'b0, "R4 carry append");

    // R4 with longest operand: sixteen bytes of 99 plus 01
    for (int i = 0; i < DEPTH; i++) begin memA[i] = 8'h99; memB[i] = 8'h55; end
    memB[0] = 8'h01;
    for (int i = 0; i < 2*DEPTH; i++) expR[i] = 8'hEE;
    for (int i = 0; i < DEPTH; i++) expR[i] = 8'h00;
    expR[DEPTH] = 8'h01;
    expLen = DEPTH + 1;
    runAdd(DEPTH, 1, 1'b0, "R4 full length");

    // R9 both lengths zero
    for (int i = 0; i < 2*DEPTH; i++) expR[i] = 8'hEE;
    expLen = 0;
    runAdd(0, 0, 1'b0, "R9 zero length");

    // R8 stray start during run is ignored
    for (int i = 0; i < DEPTH; i++) begin memA[i] = randBcd(); memB[i] = randBcd(); end
    buildExpect(6, 2);
    runAdd(6, 2, 1'b1, "R8 stray start");

    // random operands of 1..8 bytes; lengths past end filled with garbage (R5)
    for (int n = 0; n < 40; n++) begin
      int la = $urandom_range(8, 1);
      int lb = $urandom_range(8, 1);
      for (int i = 0; i < DEPTH; i++) begin
        memA[i] = (i < la) ? randBcd() : 8'($urandom);
        memB[i] = (i < lb) ? randBcd() : 8'($urandom);
      end
      buildExpect(la, lb);
      runAdd(la, lb, n[0], "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule